// File: doc/BRIEF.md
# Condition Code Flag Register

This block keeps the processor's status flags: carry, zero, overflow and negative. The control logic reads all four flags at the same time, in parallel. The flags can be written from three places. The ALU writes them with a per-flag mask, so that an operation changes only the flags it affects. A saved flag set can be restored from the low bits of the data bus in one clock. A bit-serial restore path shifts in one bit per clock. The register can place its contents on the data bus in one cycle, so the flags can be saved to memory.

A fifth, microcode-only carry bit sits beside the visible flags. Effective-address arithmetic uses it to carry from the low byte into the high byte. Because it is a separate bit, indexed add and subtract instructions can still read the visible carry after the address is computed. This hidden bit is loaded through its own enable and is never placed on the bus.

Top module: `ccr_flags`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four visible flags and the hidden carry to 0.
- R2: When none of `bus_ld`, `alu_ld`, `ser_shift` or `hid_ld` is asserted, both the flags and the hidden carry keep their values.
- R3: With `bus_ld` high, the visible flags take `bus_in[3:0]` at the next edge: bit 0 is carry, bit 1 is zero, bit 2 is overflow and bit 3 is negative.
- R4: With `alu_ld` high and `bus_ld` low, each flag whose `alu_mask` bit is 1 takes the matching `alu_flags` bit. Every flag whose mask bit is 0 keeps its value.
- R5: With `ser_shift` high and no parallel load, the flags shift one place toward bit 0 and `ser_in` enters at bit 3. Shifting in the bits for positions 0, 1, 2 and 3, in that order, restores a whole flag set in four clocks.
- R6: When more than one load is requested in the same cycle, the bus load wins over the ALU load, and the ALU load wins over the serial shift.
- R7: `hid_ld` writes `hid_cy_in` into the hidden carry and never changes a visible flag. A visible-flag load never changes the hidden carry. A hidden load and a visible load in the same cycle both take effect.
- R8: While `bus_oe` is high, `bus_drive` is 1 and `bus_out` carries the four flags in bits 3:0 with zeros above them. While `bus_oe` is low, `bus_drive` is 0 and `bus_out` is 0. The hidden carry never appears on `bus_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_flags | input | 4 | New flag values from the ALU |
| alu_mask | input | 4 | Per-flag update mask for the ALU load (1 = update) |
| alu_ld | input | 1 | ALU load enable |
| bus_in | input | 8 | Data bus input; bits 3:0 are used for the restore |
| bus_ld | input | 1 | Single-cycle restore from the bus |
| ser_in | input | 1 | Serial restore bit |
| ser_shift | input | 1 | Serial shift enable |
| hid_cy_in | input | 1 | New value for the hidden address carry |
| hid_ld | input | 1 | Hidden carry load enable |
| bus_oe | input | 1 | Drive the flags onto the bus |
| bus_out | output | 8 | Data driven toward the bus |
| bus_drive | output | 1 | High when `bus_out` should be driven |
| flags | output | 4 | Visible flags, presented in parallel |
| hid_cy | output | 1 | Hidden address carry, for the microcode |

## Verification
The bench builds the block with its default parameters: four flags and an 8-bit bus. This leaves four bus bits above the flag field. The bench can therefore check that bus bits 7:4 stay zero even when the hidden carry is set, and that bits 7:4 of the bus input are ignored on restore. These widths also allow a full four-clock serial restore, with a check of the half-restored value after the second shift.

// File: rtl/ccr_flags.sv
module ccr_flags #(
  parameter int NF    = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF-1:0]    alu_flags,
  input  logic [NF-1:0]    alu_mask,
  input  logic             alu_ld,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             bus_ld,
  input  logic             ser_in,
  input  logic             ser_shift,
  input  logic             hid_cy_in,
  input  logic             hid_ld,
  input  logic             bus_oe,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_drive,
  output logic [NF-1:0]    flags,
  output logic             hid_cy
);

  localparam int PAD = BUS_W - NF;

  logic [NF-1:0] vis_q, vis_d;
  logic          hid_q;

  always_comb begin
    vis_d = vis_q;
    if (bus_ld)
      vis_d = bus_in[NF-1:0];
    else if (alu_ld)
      vis_d = (vis_q & ~alu_mask) | (alu_flags & alu_mask);
    else if (ser_shift)
      vis_d = {ser_in, vis_q[NF-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q <= '0;
      hid_q <= 1'b0;
    end else begin
      vis_q <= vis_d;
      if (hid_ld) hid_q <= hid_cy_in;
    end
  end

  assign flags     = vis_q;
  assign hid_cy    = hid_q;
  assign bus_drive = bus_oe;
  assign bus_out   = bus_oe ? {{PAD{1'b0}}, vis_q} : '0;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (flags == '0 && hid_cy == 1'b0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!bus_ld && !alu_ld && !ser_shift && !hid_ld) |=> ($stable(flags) && $stable(hid_cy))); // R2
  AST_BUS_RESTORE: assert property (@(posedge clk) disable iff (rst)
    bus_ld |=> flags == $past(bus_in[NF-1:0])); // R3
  AST_ALU_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (alu_ld && !bus_ld) |=> ((flags & ~$past(alu_mask)) == ($past(flags) & ~$past(alu_mask)))); // R4
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (ser_shift && !alu_ld && !bus_ld) |=> (flags[NF-2:0] == $past(flags[NF-1:1]) && flags[NF-1] == $past(ser_in))); // R5
  AST_HIDDEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hid_ld && !bus_ld && !alu_ld && !ser_shift) |=> $stable(flags)); // R7
  AST_VISIBLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!hid_ld) |=> $stable(hid_cy)); // R7
  AST_BUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_out[BUS_W-1:NF] == '0); // R8

endmodule

// File: tb/ccr_flags_tb_top.sv
module ccr_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] alu_flags, alu_mask;
  logic       alu_ld, bus_ld, ser_in, ser_shift, hid_cy_in, hid_ld, bus_oe;
  logic [7:0] bus_in, bus_out;
  logic       bus_drive, hid_cy;
  logic [3:0] flags;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ccr_flags dut_i (
    .clk(clk), .rst(rst), .alu_flags(alu_flags), .alu_mask(alu_mask), .alu_ld(alu_ld),
    .bus_in(bus_in), .bus_ld(bus_ld), .ser_in(ser_in), .ser_shift(ser_shift),
    .hid_cy_in(hid_cy_in), .hid_ld(hid_ld), .bus_oe(bus_oe), .bus_out(bus_out),
    .bus_drive(bus_drive), .flags(flags), .hid_cy(hid_cy)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    alu_flags = '0; alu_mask = '0; alu_ld = 0; bus_in = '0; bus_ld = 0;
    ser_in = 0; ser_shift = 0; hid_cy_in = 0; hid_ld = 0; bus_oe = 0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_bus(input logic [7:0] v);
    idle(); bus_ld = 1; bus_in = v; tick(); idle();
  endtask

  task automatic t_reset;
    idle(); rst = 1; tick(); tick();
    check("R1 flags", {4'h0, flags}, 8'h00);
    check("R1 hidden", {7'h0, hid_cy}, 8'h00);
    load_bus(8'h0F);
    rst = 0; idle(); hid_ld = 1; hid_cy_in = 1; tick(); idle();
    rst = 1; tick(); rst = 0;
    check("R1 flags after set", {4'h0, flags}, 8'h00);
    check("R1 hidden after set", {7'h0, hid_cy}, 8'h00);
  endtask

  task automatic t_hold;
    load_bus(8'h06);
    idle(); alu_flags = 4'hF; ser_in = 1; hid_cy_in = 1; bus_in = 8'hFF;
    tick(); tick();
    check("R2 hold flags", {4'h0, flags}, 8'h06);
    check("R2 hold hidden", {7'h0, hid_cy}, 8'h00);
  endtask

  task automatic t_bus_load;
    load_bus(8'hA9);
    check("R3 restore low nibble", {4'h0, flags}, 8'h09);
    load_bus(8'h54);
    check("R3 restore second", {4'h0, flags}, 8'h04);
  endtask

  task automatic t_alu;
    load_bus(8'h05);
    idle(); alu_ld = 1; alu_flags = 4'hA; alu_mask = 4'hF; tick(); idle();
    check("R4 full mask", {4'h0, flags}, 8'h0A);
    idle(); alu_ld = 1; alu_flags = 4'h5; alu_mask = 4'h3; tick(); idle();
    check("R4 partial mask", {4'h0, flags}, 8'h09);
    idle(); alu_ld = 1; alu_flags = 4'h6; alu_mask = 4'h0; tick(); idle();
    check("R4 empty mask", {4'h0, flags}, 8'h09);
  endtask

  task automatic t_serial;
    load_bus(8'h00);
    idle(); ser_shift = 1;
    ser_in = 1; tick();
    ser_in = 0; tick();
    idle();
    check("R5 half restore", {4'h0, flags}, 8'h04);
    ser_shift = 1;
    ser_in = 1; tick();
    ser_in = 1; tick();
    idle();
    check("R5 full restore", {4'h0, flags}, 8'h0D);
  endtask

  task automatic t_priority;
    load_bus(8'h00);
    idle(); bus_ld = 1; bus_in = 8'h05; alu_ld = 1; alu_flags = 4'hF; alu_mask = 4'hF;
    ser_shift = 1; ser_in = 1; tick(); idle();
    check("R6 bus over alu and shift", {4'h0, flags}, 8'h05);
    idle(); alu_ld = 1; alu_flags = 4'hA; alu_mask = 4'hF; ser_shift = 1; ser_in = 1;
    tick(); idle();
    check("R6 alu over shift", {4'h0, flags}, 8'h0A);
  endtask

  task automatic t_hidden;
    load_bus(8'h0F);
    idle(); hid_ld = 1; hid_cy_in = 1; tick(); idle();
    check("R7 hidden set", {7'h0, hid_cy}, 8'h01);
    check("R7 visible untouched", {4'h0, flags}, 8'h0F);
    load_bus(8'h02);
    idle(); alu_ld = 1; alu_flags = 4'h0; alu_mask = 4'hF; tick();
    idle(); ser_shift = 1; ser_in = 0; tick(); idle();
    check("R7 hidden kept over visible loads", {7'h0, hid_cy}, 8'h01);
    idle(); hid_ld = 1; hid_cy_in = 0; alu_ld = 1; alu_flags = 4'h8; alu_mask = 4'hF;
    tick(); idle();
    check("R7 same cycle hidden", {7'h0, hid_cy}, 8'h00);
    check("R7 same cycle visible", {4'h0, flags}, 8'h08);
  endtask

  task automatic t_bus_out;
    load_bus(8'h09);
    idle(); hid_ld = 1; hid_cy_in = 1; tick(); idle();
    bus_oe = 1; #1;
    check("R8 drive on", {7'h0, bus_drive}, 8'h01);
    check("R8 bus value", bus_out, 8'h09);
    bus_oe = 0; #1;
    check("R8 drive off", {7'h0, bus_drive}, 8'h00);
    check("R8 bus quiet", bus_out, 8'h00);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; idle();
    t_reset();
    t_hold();
    t_bus_load();
    t_alu();
    t_serial();
    t_priority();
    t_hidden();
    t_bus_out();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule